// File: doc/BRIEF.md
# Metering Clock Controller

This block sits beside the processor of a metering microcontroller and manages its clocks. It runs on the master clock that an external PLL delivers. From that clock it makes a divided processor clock whose period is a power of two, and an emulator clock at half the master rate. The block holds one control byte. The byte has a fast/slow PLL speed request and a three-bit processor divider code. The block also reports a read-only PLL-ready status bit.

The PLL enable follows the power mode. Active mode keeps the PLL running. Sleep mode stops it. LCD-only mode keeps it running only when the LCD boost supply is enabled. A fast-speed request never reaches the PLL while the PLL is not ready. Such a request waits as a pending request until the ready flag rises. While the PLL is off, the speed request is held at slow, so each wake-up starts in the slow setting. A divider change waits for the end of the current divided-clock period, so the processor clock never shows a short pulse.

Top module: `clk_ctrl_unit`

## Requirements
- R1: During reset, `rd_data`, `pll_en`, `pll_fast_req`, `mpu_clk` and `emu_clk` are all 0.
- R2: A write stores `wr_data[2:0]` as the divider code N and reads it back on `rd_data[2:0]`. Codes 5, 6 and 7 are stored as 4. Bits 7:6 of `rd_data` always read 0. Write bits 7:5 and 3 have no effect.
- R3: With divider code N, `mpu_clk` has a period of 2^(N+2) master cycles. It is low for the first half of the period and high for the second half. `mpu_tick` is high in the last master cycle of each period.
- R4: A new divider code takes effect only at a period boundary, so the period in progress ends with its old length. A write made in the last cycle of a period sets the length of the very next period.
- R5: `pwr_mode` encodes 00 = active, 01 = sleep, 10 = LCD-only and 11 = sleep. `pll_en` becomes 1 one cycle after active mode, or LCD-only mode with `lcd_boost_en` high. It becomes 0 one cycle after any other mode.
- R6: `pll_ok`, also read on `rd_data[5]`, equals `pll_lock_in` registered once, ANDed with `pll_en`. It is 0 whenever `pll_en` is 0.
- R7: A write made while `pll_ok` is 1 sets `pll_fast_req` (also read on `rd_data[4]`) to `wr_data[4]` in the next cycle.
- R8: A write made while `pll_ok` is 0 leaves `pll_fast_req` unchanged and sets the pending flag `rd_data[3]`. The pending value is applied, and the flag cleared, on the clock edge that ends the first cycle in which `pll_ok` is 1.
- R9: While `pll_en` is 0, `pll_fast_req` is forced to 0, so after a wake it stays 0 until a request is applied.
- R10: While `emu_en` is 1, `emu_clk` toggles on every master edge. When `emu_en` goes to 0, `emu_clk` returns to 0 and stays there.
- R11: If a write falls in the same cycle as the release of a pending request, the written value wins and the pending flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 4 fast request, bits 2:0 divider code |
| rd_data | output | 8 | Readback: bit 5 ready, bit 4 fast, bit 3 pending, bits 2:0 divider |
| pwr_mode | input | 2 | Power mode code |
| lcd_boost_en | input | 1 | LCD boost supply enabled |
| emu_en | input | 1 | Emulator clock enable |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| pll_en | output | 1 | PLL enable |
| pll_fast_req | output | 1 | PLL fast-speed request |
| pll_ok | output | 1 | PLL ready status |
| mpu_clk | output | 1 | Divided processor clock |
| mpu_tick | output | 1 | Last master cycle of a processor clock period |
| emu_clk | output | 1 | Emulator clock, master divided by two |

## Verification
Two events can land on the same master edge. The first pair is a register write and a divider period boundary. The bench provokes it by writing in the cycle where `mpu_tick` is seen high, then checks that the very next period already has the new length. The second pair is a write and the release of a pending speed request. The bench parks a fast request while the PLL is locking, then writes slow in the first cycle `pll_ok` reads high. It expects `pll_fast_req` to stay 0 and the pending flag to clear.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int DIV_W    = 3;
  localparam int DIV_MAX  = 4;
  localparam int CNT_W    = DIV_MAX + 2;
  localparam int REG_W    = 8;
  localparam int FAST_BIT = 4;
  localparam int PEND_BIT = 3;
  localparam int OK_BIT   = 5;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_SLEEP  = 2'b01,
    PM_LCD    = 2'b10,
    PM_RSVD   = 2'b11
  } pwr_mode_e;

  // Bring a divider code into the legal range.
  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
    return (v > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : v;
  endfunction

  // Terminal count of a period of 2^(d+2) master cycles.
  function automatic logic [CNT_W-1:0] last_count(input logic [DIV_W-1:0] d);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (one << (d + DIV_W'(2))) - CNT_W'(1);
  endfunction

  // Processor clock level for a count: high in the second half of the period.
  function automatic logic half_level(input logic [CNT_W-1:0] c,
                                      input logic [DIV_W-1:0] d);
    logic [CNT_W-1:0] sh;
    sh = c >> (d + DIV_W'(1));
    return sh[0];
  endfunction

  // PLL must run in active mode, and in LCD mode when boost is on.
  function automatic logic pll_should_run(input pwr_mode_e m, input logic boost);
    case (m)
      PM_ACTIVE: return 1'b1;
      PM_LCD:    return boost;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/clk_ctrl_pll.sv
module clk_ctrl_pll
  import clk_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_mode,
  input  logic       lcd_boost_en,
  input  logic       pll_lock_in,
  output logic       pll_en,
  output logic       pll_ok
);
  logic      en_q;
  logic      lock_q;
  pwr_mode_e mode;

  assign mode = pwr_mode_e'(pwr_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      en_q   <= pll_should_run(mode, lcd_boost_en);
      lock_q <= pll_lock_in;
    end
  end

  assign pll_en = en_q;
  assign pll_ok = lock_q & en_q;
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_fast,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             pll_en,
  input  logic             pll_ok,
  output logic             fast_q,
  output logic             pend_q,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_next
);
  logic pend_val_q;
  logic release_evt;

  assign release_evt = pend_q & pll_ok & ~wr_en;
  assign div_next    = wr_en ? clamp_div(wr_div) : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_val_q <= 1'b0;
      div_q      <= '0;
    end else begin
      div_q <= div_next;
      if (wr_en) begin
        if (pll_ok) begin
          fast_q <= wr_fast;
          pend_q <= 1'b0;
        end else begin
          pend_q     <= 1'b1;
          pend_val_q <= wr_fast;
        end
      end else if (release_evt) begin
        fast_q <= pend_val_q;
        pend_q <= 1'b0;
      end
      if (!pll_en) begin
        fast_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_ctrl_mpu_div.sv
module clk_ctrl_mpu_div
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_next,
  output logic             mpu_clk,
  output logic             mpu_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             clk_q;
  logic             wrap;

  assign wrap  = (cnt_q == last_count(act_q));
  assign act_d = wrap ? div_next : act_q;
  assign cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      clk_q <= half_level(cnt_d, act_d);
    end
  end

  assign mpu_clk  = clk_q;
  assign mpu_tick = wrap;
endmodule

// File: rtl/clk_ctrl_emu_div.sv
module clk_ctrl_emu_div (
  input  logic clk,
  input  logic rst_n,
  input  logic emu_en,
  output logic emu_clk
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= emu_en ? ~tog_q : 1'b0;
  end

  assign emu_clk = tog_q;
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [1:0]       pwr_mode,
  input  logic             lcd_boost_en,
  input  logic             emu_en,
  input  logic             pll_lock_in,
  output logic             pll_en,
  output logic             pll_fast_req,
  output logic             pll_ok,
  output logic             mpu_clk,
  output logic             mpu_tick,
  output logic             emu_clk
);
  logic             fast_q;
  logic             pend_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:FAST_BIT+1], wr_data[FAST_BIT-1:DIV_W]};

  clk_ctrl_pll u_pll (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_mode     (pwr_mode),
    .lcd_boost_en (lcd_boost_en),
    .pll_lock_in  (pll_lock_in),
    .pll_en       (pll_en),
    .pll_ok       (pll_ok)
  );

  clk_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_fast  (wr_data[FAST_BIT]),
    .wr_div   (wr_data[DIV_W-1:0]),
    .pll_en   (pll_en),
    .pll_ok   (pll_ok),
    .fast_q   (fast_q),
    .pend_q   (pend_q),
    .div_q    (div_q),
    .div_next (div_next)
  );

  clk_ctrl_mpu_div u_mdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_next (div_next),
    .mpu_clk  (mpu_clk),
    .mpu_tick (mpu_tick)
  );

  clk_ctrl_emu_div u_edv (
    .clk     (clk),
    .rst_n   (rst_n),
    .emu_en  (emu_en),
    .emu_clk (emu_clk)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[DIV_W-1:0]   = div_q;
    rd_data[PEND_BIT]    = pend_q;
    rd_data[FAST_BIT]    = fast_q;
    rd_data[OK_BIT]      = pll_ok;
  end

  assign pll_fast_req = fast_q;
endmodule

// File: rtl/clk_ctrl_unit_chk.sv
module clk_ctrl_unit_chk
  import clk_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_rb,
  input logic [1:0]       pwr_mode,
  input logic             emu_en,
  input logic             pll_en,
  input logic             pll_fast_req,
  input logic             pll_ok,
  input logic             mpu_clk,
  input logic             mpu_tick,
  input logic             emu_clk
);
  p_div_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_rb <= DIV_W'(DIV_MAX));

  p_period_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mpu_tick |=> !mpu_clk);

  p_sleep_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b01) |=> !pll_en);

  p_ok_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> !pll_ok);

  p_fast_after_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_fast_req) |-> $past(pll_ok));

  p_off_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> !pll_fast_req);

  p_emu_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(emu_en) |-> (emu_clk != $past(emu_clk)));

  p_emu_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_en && !emu_clk) |=> !emu_clk);
endmodule

bind clk_ctrl_unit clk_ctrl_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .div_rb       (rd_data[2:0]),
  .pwr_mode     (pwr_mode),
  .emu_en       (emu_en),
  .pll_en       (pll_en),
  .pll_fast_req (pll_fast_req),
  .pll_ok       (pll_ok),
  .mpu_clk      (mpu_clk),
  .mpu_tick     (mpu_tick),
  .emu_clk      (emu_clk)
);

// File: tb/tb_clk_ctrl_unit.sv
module tb_clk_ctrl_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LOCK_CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] pwr_mode = 2'b00;
  logic       lcd_boost_en = 1'b0;
  logic       emu_en = 1'b0;
  logic       pll_lock_in;
  logic       pll_en, pll_fast_req, pll_ok, mpu_clk, mpu_tick, emu_clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int lock_cnt = 0;

  always #10 clk = ~clk;

  clk_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pwr_mode(pwr_mode), .lcd_boost_en(lcd_boost_en), .emu_en(emu_en),
    .pll_lock_in(pll_lock_in), .pll_en(pll_en), .pll_fast_req(pll_fast_req),
    .pll_ok(pll_ok), .mpu_clk(mpu_clk), .mpu_tick(mpu_tick), .emu_clk(emu_clk)
  );

  // PLL stub: lock after LOCK_CYC enabled cycles, lost at once when disabled.
  always @(posedge clk) begin
    if (!pll_en) lock_cnt <= 0;
    else if (lock_cnt < LOCK_CYC) lock_cnt <= lock_cnt + 1;
  end
  assign pll_lock_in = (lock_cnt == LOCK_CYC);

  function automatic int exp_code(input int d);
    return (d > 4) ? 4 : d;
  endfunction
  function automatic int exp_period(input int d);
    return 4 * (2 ** exp_code(d));
  endfunction
  function automatic bit exp_pll_run(input logic [1:0] m, input logic b);
    return (m == 2'b00) || (m == 2'b10 && b);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ok();
    for (int n = 0; n < 200 && !pll_ok; n++) @(negedge clk);
  endtask

  task automatic wait_tick();
    for (int n = 0; n < 200 && !mpu_tick; n++) @(negedge clk);
  endtask

  task automatic meas(output int per, output int hi);
    wait_tick();
    per = 0;
    hi = 0;
    do begin
      @(negedge clk);
      per++;
      if (mpu_clk) hi++;
    end while (!mpu_tick && per < 200);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int per, hi, cnt;
    void'($urandom(32'h5eed1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data, 0);
    check("R1 pll_en", pll_en, 0);
    check("R1 fast", pll_fast_req, 0);
    check("R1 mpu_clk", mpu_clk, 0);
    check("R1 emu_clk", emu_clk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 active enables", pll_en, 1);
    check("R6 ok low while locking", pll_ok, 0);

    // R8 fast request while not ready is held
    wr(8'h10);
    check("R8 pending flag", rd_data[3], 1);
    check("R8 no early fast", pll_fast_req, 0);
    wait_ok();
    check("R6 ok bit reads", rd_data[5], 1);
    check("R8 not yet applied", pll_fast_req, 0);
    @(negedge clk);
    check("R8 applied", pll_fast_req, 1);
    check("R8 pending cleared", rd_data[3], 0);

    // R7 direct writes while ready
    wr(8'h00);
    check("R7 slow", pll_fast_req, 0);
    wr(8'h10);
    check("R7 fast", rd_data[4], 1);

    // R5 / R6 / R9 mode sweep
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      logic b;
      m = 2'(i >> 1);
      b = 1'(i);
      pwr_mode = m;
      lcd_boost_en = b;
      @(negedge clk);
      check("R5 pll_en by mode", pll_en, exp_pll_run(m, b));
      if (!pll_en) begin
        check("R6 ok forced low", pll_ok, 0);
        @(negedge clk);
        check("R9 slow while off", pll_fast_req, 0);
      end
    end
    pwr_mode = 2'b01;
    @(negedge clk);
    pwr_mode = 2'b00;
    @(negedge clk);
    check("R9 wake slow", pll_fast_req, 0);

    // R11 write coincides with release of pending request
    wr(8'h10);
    check("R11 pending set", rd_data[3], 1);
    wait_ok();
    wr(8'h00);
    check("R11 write wins", pll_fast_req, 0);
    check("R11 pending cleared", rd_data[3], 0);
    @(negedge clk);
    check("R11 stays slow", pll_fast_req, 0);

    // R2 clamp and ignored bits
    wr(8'hEF);
    check("R2 clamp 7", rd_data[2:0], 4);
    check("R2 reserved zero", rd_data[7:6], 0);
    check("R2 bit3 ignored", rd_data[3], 0);
    meas(per, hi);
    meas(per, hi);
    check("R3 period code 4", per, 64);

    // R4 change mid-period waits for boundary
    wait_tick();
    @(negedge clk);
    cnt = 1;
    wr(8'h10);
    cnt++;
    while (!mpu_tick && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check("R4 old period completes", cnt, 64);
    meas(per, hi);
    check("R4 new period", per, 4);

    // R4 write in last cycle of period governs next period
    wr(8'h14);
    meas(per, hi);
    meas(per, hi);
    wait_tick();
    wr(8'h12);
    cnt = 1;
    while (!mpu_tick && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check("R4 boundary write", cnt, 16);

    // R3 / R2 random divider codes
    for (int i = 0; i < 16; i++) begin
      int d;
      logic [7:0] v;
      d = int'($urandom % 8);
      v = 8'($urandom);
      v[4] = 1'b1;
      v[2:0] = 3'(d);
      repeat ($urandom % 5) @(negedge clk);
      wr(v);
      check("R2 readback", rd_data[2:0], exp_code(d));
      meas(per, hi);
      meas(per, hi);
      check("R3 period", per, exp_period(d));
      check("R3 high half", hi, exp_period(d) / 2);
    end

    // R10 emulator clock
    emu_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = emu_clk;
      @(negedge clk);
      check("R10 toggles", emu_clk, !prev);
    end
    emu_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle low", emu_clk, 0);
    @(negedge clk);
    check("R10 stays low", emu_clk, 0);

    finish_run();
  end
endmodule